// File: doc/BRIEF.md
# Duplex Port Access Decoder with Mailboxes

This block is the access control for a device that carries words in both directions between two ports: one FIFO runs from port A to port B, a second runs from port B to port A, and each direction also has a one-word mailbox that bypasses the FIFO. For each port, a chip select, a direction select, an enable and a mailbox select are decoded into one of four operations: push into the outbound FIFO, pop from the inbound FIFO, write the outbound mailbox, or read the inbound mailbox. The block also drives the output enable for that port's shared bidirectional data bus. The FIFO storage arrays are outside the block. A FIFO access is gated by the FIFO's ready flag. A mailbox access is not gated by any flag.

Each port has a small state machine whose state is the operation issued at the last clock edge. The states are IDLE, PUSH, POP, MAIL_WR and MAIL_RD. On every edge the machine moves to the state decoded from the inputs sampled at that edge. When no valid access is decoded it moves to IDLE, and there are no other transitions. The strobe for a state is asserted while the machine is in that state. Because the strobes are registered, each port issues at most one operation per edge. The mailbox contents and the read data register update on the edge that ends the state, so they appear one cycle after the strobe. Both ports share one clock, and the direction select on port B has the opposite polarity to the one on port A.

Top module: `duplex_port_ctrl`

## Requirements
- R1: `pa_drive` is 1 exactly when `pa_sel_n` is 0 and `pa_dir` is 0, combinationally from the current inputs. `pb_drive` is 1 exactly when `pb_sel_n` is 0 and `pb_dir` is 1.
- R2: A port accesses in write direction when its select is low and its enable is high. For port A, write direction is `pa_dir`=1; for port B, see R6. If such an access is sampled at an edge with the mailbox select low and the outbound ready flag high, then the push strobe is high for the following cycle, and the push data equals the bus input sampled at that edge. If the ready flag is low, no strobe is issued.
- R3: A port accesses in read direction when its select is low and its enable is high. If such an access is sampled with the mailbox select low and the inbound valid flag high, then the pop strobe is high for the following cycle. On the edge that ends that cycle, the port's output data takes the inbound data input as it stands during the strobe cycle. If the valid flag is low, no strobe is issued.
- R4: When the mailbox select is high, the same access becomes a mailbox operation, and the FIFO flags are ignored. A write sets the mail-write state for one cycle and stores the captured word in the outbound mailbox on the next edge. A read sets the mail-read state and loads the inbound mailbox into the port's output data on the next edge.
- R5: When a mailbox is read, its empty flag goes to 1 on the edge that completes the read. This does not apply if R10 also applies in that edge.
- R6: Port B uses the same decode as port A with the direction select inverted. On port B, `pb_dir`=0 selects write and `pb_dir`=1 selects read and bus drive.
- R7: When enable is low, a port issues no operation at that edge, whatever its select, direction and mailbox inputs are. Its push data and output data do not change.
- R8: The two ports decode independently. Operations sampled on the same edge on both ports are all carried out.
- R9: A mailbox write drives that mailbox's empty flag to 0 on the edge that completes it. After reset, both empty flags are 1, all strobes are 0, and the output data and mailbox contents are 0.
- R10: Each port issues at most one strobe per cycle. If a write and a read of the same mailbox complete on the same edge, the flag becomes 0, and the reader receives the contents the mailbox held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pa_sel_n | input | 1 | Port A select, active low |
| pa_dir | input | 1 | Port A direction: 1 write, 0 read/drive |
| pa_en | input | 1 | Port A access enable |
| pa_mail | input | 1 | Port A mailbox select |
| pa_din | input | 36 | Port A bus input word |
| pa_dout | output | 36 | Port A read data register |
| pa_drive | output | 1 | Port A bus output enable |
| pa_ob_ready | input | 1 | A-to-B FIFO can accept a word |
| pa_push | output | 1 | Push strobe to the A-to-B FIFO |
| pa_push_data | output | 36 | Word for the A-to-B FIFO |
| pa_ib_valid | input | 1 | B-to-A FIFO holds a word |
| pa_ib_data | input | 36 | Head word of the B-to-A FIFO |
| pa_pop | output | 1 | Pop strobe to the B-to-A FIFO |
| pb_sel_n | input | 1 | Port B select, active low |
| pb_dir | input | 1 | Port B direction: 0 write, 1 read/drive |
| pb_en | input | 1 | Port B access enable |
| pb_mail | input | 1 | Port B mailbox select |
| pb_din | input | 36 | Port B bus input word |
| pb_dout | output | 36 | Port B read data register |
| pb_drive | output | 1 | Port B bus output enable |
| pb_ob_ready | input | 1 | B-to-A FIFO can accept a word |
| pb_push | output | 1 | Push strobe to the B-to-A FIFO |
| pb_push_data | output | 36 | Word for the B-to-A FIFO |
| pb_ib_valid | input | 1 | A-to-B FIFO holds a word |
| pb_ib_data | input | 36 | Head word of the A-to-B FIFO |
| pb_pop | output | 1 | Pop strobe to the A-to-B FIFO |
| mail_ab_empty | output | 1 | A-to-B mailbox empty flag |
| mail_ba_empty | output | 1 | B-to-A mailbox empty flag |

## Verification
Two events can complete on the same edge: one port writes a mailbox while the other port reads it. The bench provokes this by issuing a port A mail write and a port B mail read of the A-to-B mailbox in the same cycle, and then the mirror case in the other direction. Random traffic also produces it many times. The outcome is judged in three places: the empty flag must end up 0, the reader's output data must hold the contents from before the write, and a later read must return the new word.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    parameter int DATA_W = 36;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH    = 3'd1,
        ST_POP     = 3'd2,
        ST_MAIL_WR = 3'd3,
        ST_MAIL_RD = 3'd4
    } port_state_e;
endpackage

// File: rtl/dpc_mailbox.sv
module dpc_mailbox #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         empty
);
    logic [W-1:0] data_q;
    logic         empty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            empty_q <= 1'b1;
        end else if (wr) begin
            data_q  <= wdata;
            empty_q <= 1'b0;
        end else if (rd) begin
            empty_q <= 1'b1;
        end
    end

    assign data  = data_q;
    assign empty = empty_q;

    // R9: a completed write leaves mail waiting
    a_r9_flag_low_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty);
    // R5: a read with no competing write clears the waiting mail
    a_r5_flag_high_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> empty);
    // R10: the reader sees the contents from before a coinciding write
    a_r10_contents_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(data));
endmodule

// File: rtl/dpc_port_ctl.sv
module dpc_port_ctl
    import dpc_pkg::*;
#(
    parameter int   W         = 36,
    parameter logic WRITE_LVL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         dir,
    input  logic         en,
    input  logic         mail,
    input  logic [W-1:0] din,
    input  logic         ob_ready,
    input  logic         ib_valid,
    input  logic [W-1:0] ib_data,
    input  logic [W-1:0] mail_in,
    output logic         drive,
    output logic [W-1:0] dout,
    output logic         push,
    output logic         pop,
    output logic         mail_wr,
    output logic         mail_rd,
    output logic [W-1:0] wdata
);
    localparam logic READ_LVL = ~WRITE_LVL;

    port_state_e  state_q, state_d;
    logic [W-1:0] wdata_q;
    logic [W-1:0] dout_q;
    logic         access;
    logic         is_write;

    assign access   = !sel_n && en;
    assign is_write = (dir == WRITE_LVL);
    assign drive    = !sel_n && (dir == READ_LVL);

    // next state: the operation decoded at this edge
    always_comb begin
        state_d = ST_IDLE;
        if (access) begin
            if (mail)
                state_d = is_write ? ST_MAIL_WR : ST_MAIL_RD;
            else if (is_write)
                state_d = ob_ready ? ST_PUSH : ST_IDLE;
            else
                state_d = ib_valid ? ST_POP : ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            dout_q  <= '0;
        end else begin
            if (access && is_write)
                wdata_q <= din;
            if (state_q == ST_POP)
                dout_q <= ib_data;
            else if (state_q == ST_MAIL_RD)
                dout_q <= mail_in;
        end
    end

    // outputs per state
    always_comb begin
        push    = 1'b0;
        pop     = 1'b0;
        mail_wr = 1'b0;
        mail_rd = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_PUSH:    push    = 1'b1;
            ST_POP:     pop     = 1'b1;
            ST_MAIL_WR: mail_wr = 1'b1;
            ST_MAIL_RD: mail_rd = 1'b1;
            default:    ;
        endcase
    end

    assign dout  = dout_q;
    assign wdata = wdata_q;

    // R2: a push only follows a gated write-direction FIFO access
    a_r2_push_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && en && !mail && ob_ready && dir == WRITE_LVL) |=> push && wdata == $past(din));
    // R3: a pop only follows a gated read-direction FIFO access
    a_r3_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && en && !mail && !ib_valid && dir == READ_LVL) |=> !pop);
    // R4: mailbox select turns a write access into a mail write regardless of flags
    a_r4_mail_write_routed: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && en && mail && dir == WRITE_LVL) |=> mail_wr && !push);
    // R7: a disabled cycle issues nothing
    a_r7_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(push || pop || mail_wr || mail_rd));
    // R10: at most one operation per edge
    a_r10_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push, pop, mail_wr, mail_rd}));
endmodule

// File: rtl/duplex_port_ctrl.sv
module duplex_port_ctrl
    import dpc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pa_sel_n,
    input  logic         pa_dir,
    input  logic         pa_en,
    input  logic         pa_mail,
    input  logic [W-1:0] pa_din,
    output logic [W-1:0] pa_dout,
    output logic         pa_drive,
    input  logic         pa_ob_ready,
    output logic         pa_push,
    output logic [W-1:0] pa_push_data,
    input  logic         pa_ib_valid,
    input  logic [W-1:0] pa_ib_data,
    output logic         pa_pop,
    input  logic         pb_sel_n,
    input  logic         pb_dir,
    input  logic         pb_en,
    input  logic         pb_mail,
    input  logic [W-1:0] pb_din,
    output logic [W-1:0] pb_dout,
    output logic         pb_drive,
    input  logic         pb_ob_ready,
    output logic         pb_push,
    output logic [W-1:0] pb_push_data,
    input  logic         pb_ib_valid,
    input  logic [W-1:0] pb_ib_data,
    output logic         pb_pop,
    output logic         mail_ab_empty,
    output logic         mail_ba_empty
);
    logic         a_mail_wr, a_mail_rd, b_mail_wr, b_mail_rd;
    logic [W-1:0] ab_data, ba_data;

    dpc_port_ctl #(.W(W), .WRITE_LVL(1'b1)) u_port_a (
        .clk(clk), .rst_n(rst_n),
        .sel_n(pa_sel_n), .dir(pa_dir), .en(pa_en), .mail(pa_mail), .din(pa_din),
        .ob_ready(pa_ob_ready), .ib_valid(pa_ib_valid), .ib_data(pa_ib_data),
        .mail_in(ba_data),
        .drive(pa_drive), .dout(pa_dout), .push(pa_push), .pop(pa_pop),
        .mail_wr(a_mail_wr), .mail_rd(a_mail_rd), .wdata(pa_push_data)
    );

    dpc_port_ctl #(.W(W), .WRITE_LVL(1'b0)) u_port_b (
        .clk(clk), .rst_n(rst_n),
        .sel_n(pb_sel_n), .dir(pb_dir), .en(pb_en), .mail(pb_mail), .din(pb_din),
        .ob_ready(pb_ob_ready), .ib_valid(pb_ib_valid), .ib_data(pb_ib_data),
        .mail_in(ab_data),
        .drive(pb_drive), .dout(pb_dout), .push(pb_push), .pop(pb_pop),
        .mail_wr(b_mail_wr), .mail_rd(b_mail_rd), .wdata(pb_push_data)
    );

    dpc_mailbox #(.W(W)) u_mail_ab (
        .clk(clk), .rst_n(rst_n),
        .wr(a_mail_wr), .wdata(pa_push_data), .rd(b_mail_rd),
        .data(ab_data), .empty(mail_ab_empty)
    );

    dpc_mailbox #(.W(W)) u_mail_ba (
        .clk(clk), .rst_n(rst_n),
        .wr(b_mail_wr), .wdata(pb_push_data), .rd(a_mail_rd),
        .data(ba_data), .empty(mail_ba_empty)
    );

    // R8: each port's strobes come only from its own inputs
    a_r8_port_b_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !pb_en |=> !(pb_push || pb_pop));
endmodule

// File: tb/tb_duplex_port_ctrl.sv
module tb_duplex_port_ctrl;
    localparam int W = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pa_sel_n = 1'b1, pa_dir = 1'b0, pa_en = 1'b0, pa_mail = 1'b0;
    logic pb_sel_n = 1'b1, pb_dir = 1'b0, pb_en = 1'b0, pb_mail = 1'b0;
    logic [W-1:0] pa_din = '0, pb_din = '0, pa_ib_data = '0, pb_ib_data = '0;
    logic pa_ob_ready = 1'b0, pa_ib_valid = 1'b0, pb_ob_ready = 1'b0, pb_ib_valid = 1'b0;
    logic [W-1:0] pa_dout, pb_dout, pa_push_data, pb_push_data;
    logic pa_drive, pb_drive, pa_push, pb_push, pa_pop, pb_pop;
    logic mail_ab_empty, mail_ba_empty;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    duplex_port_ctrl #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .pa_sel_n(pa_sel_n), .pa_dir(pa_dir), .pa_en(pa_en), .pa_mail(pa_mail),
        .pa_din(pa_din), .pa_dout(pa_dout), .pa_drive(pa_drive),
        .pa_ob_ready(pa_ob_ready), .pa_push(pa_push), .pa_push_data(pa_push_data),
        .pa_ib_valid(pa_ib_valid), .pa_ib_data(pa_ib_data), .pa_pop(pa_pop),
        .pb_sel_n(pb_sel_n), .pb_dir(pb_dir), .pb_en(pb_en), .pb_mail(pb_mail),
        .pb_din(pb_din), .pb_dout(pb_dout), .pb_drive(pb_drive),
        .pb_ob_ready(pb_ob_ready), .pb_push(pb_push), .pb_push_data(pb_push_data),
        .pb_ib_valid(pb_ib_valid), .pb_ib_data(pb_ib_data), .pb_pop(pb_pop),
        .mail_ab_empty(mail_ab_empty), .mail_ba_empty(mail_ba_empty)
    );

    // reference model: 0 none, 1 push, 2 pop, 3 mail write, 4 mail read
    int m_opa = 0, m_opb = 0;
    logic [W-1:0] m_wa = '0, m_wb = '0, m_da = '0, m_db = '0, m_ab = '0, m_ba = '0;
    logic m_ab_e = 1'b1, m_ba_e = 1'b1;

    function automatic int decode(logic sel_n, logic en, logic wr, logic mail,
                                  logic rdy, logic vld);
        if (sel_n || !en) return 0;
        if (mail) return wr ? 3 : 4;
        if (wr) return rdy ? 1 : 0;
        return vld ? 2 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_opa = 0; m_opb = 0; m_wa = '0; m_wb = '0; m_da = '0; m_db = '0;
            m_ab = '0; m_ba = '0; m_ab_e = 1'b1; m_ba_e = 1'b1;
        end else begin
            if (m_opa == 2) m_da = pa_ib_data;
            if (m_opa == 4) m_da = m_ba;
            if (m_opb == 2) m_db = pb_ib_data;
            if (m_opb == 4) m_db = m_ab;
            if (m_opa == 3) begin m_ab = m_wa; m_ab_e = 1'b0; end
            else if (m_opb == 4) m_ab_e = 1'b1;
            if (m_opb == 3) begin m_ba = m_wb; m_ba_e = 1'b0; end
            else if (m_opa == 4) m_ba_e = 1'b1;
            m_opa = decode(pa_sel_n, pa_en, pa_dir, pa_mail, pa_ob_ready, pa_ib_valid);
            m_opb = decode(pb_sel_n, pb_en, !pb_dir, pb_mail, pb_ob_ready, pb_ib_valid);
            if (!pa_sel_n && pa_en && pa_dir) m_wa = pa_din;
            if (!pb_sel_n && pb_en && !pb_dir) m_wb = pb_din;
        end
    end

    task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_regs();
        chk("R2", "pa_push", W'(pa_push), W'(m_opa == 1));
        chk("R6", "pb_push", W'(pb_push), W'(m_opb == 1));
        chk("R3", "pa_pop", W'(pa_pop), W'(m_opa == 2));
        chk("R6", "pb_pop", W'(pb_pop), W'(m_opb == 2));
        if (m_opa == 1) chk("R2", "pa_push_data", pa_push_data, m_wa);
        if (m_opb == 1) chk("R8", "pb_push_data", pb_push_data, m_wb);
        chk("R4", "pa_dout", pa_dout, m_da);
        chk("R4", "pb_dout", pb_dout, m_db);
        chk("R9", "mail_ab_empty", W'(mail_ab_empty), W'(m_ab_e));
        chk("R5", "mail_ba_empty", W'(mail_ba_empty), W'(m_ba_e));
        chk("R10", "pa single op", W'($countones({pa_push, pa_pop})), W'((m_opa == 1) || (m_opa == 2)));
    endtask

    task automatic drive_cycle(logic as, logic ad, logic ae, logic am, logic [W-1:0] adin,
                               logic bs, logic bd, logic be, logic bm, logic [W-1:0] bdin);
        @(negedge clk);
        compare_regs();
        pa_sel_n = as; pa_dir = ad; pa_en = ae; pa_mail = am; pa_din = adin;
        pb_sel_n = bs; pb_dir = bd; pb_en = be; pb_mail = bm; pb_din = bdin;
        pa_ib_data = {4'h0, $urandom()};
        pb_ib_data = {4'h1, $urandom()};
        #1;
        chk("R1", "pa_drive", W'(pa_drive), W'(!pa_sel_n && !pa_dir));
        chk("R6", "pb_drive", W'(pb_drive), W'(!pb_sel_n && pb_dir));
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        @(negedge clk);
        chk("R9", "reset mail_ab_empty", W'(mail_ab_empty), W'(1));
        chk("R9", "reset pa_dout", pa_dout, '0);
        pa_ob_ready = 1'b1; pa_ib_valid = 1'b1; pb_ob_ready = 1'b1; pb_ib_valid = 1'b1;
        // R10: A writes A-to-B mail, then A writes again while B reads it
        drive_cycle(0, 1, 1, 1, 36'h111111111, 1, 0, 0, 0, '0);
        drive_cycle(0, 1, 1, 1, 36'h222222222, 0, 1, 1, 1, '0);
        drive_cycle(1, 0, 0, 0, '0, 1, 0, 0, 0, '0);
        drive_cycle(1, 0, 0, 0, '0, 0, 1, 1, 1, '0);
        // R10 mirror: B writes B-to-A mail while A reads it
        drive_cycle(1, 0, 0, 0, '0, 0, 0, 1, 1, 36'h333333333);
        drive_cycle(0, 0, 1, 1, '0, 0, 0, 1, 1, 36'h444444444);
        drive_cycle(0, 0, 1, 1, '0, 1, 0, 0, 0, '0);
        // R7: enable low with select and direction toggling
        drive_cycle(0, 1, 0, 0, 36'hABCDE, 0, 0, 0, 0, 36'h12345);
        drive_cycle(0, 0, 0, 1, 36'h55555, 0, 1, 0, 1, 36'h66666);
        // R2/R3: flags low block FIFO access; R4: mailbox ignores them
        pa_ob_ready = 1'b0; pb_ib_valid = 1'b0;
        drive_cycle(0, 1, 1, 0, 36'h7, 0, 1, 1, 0, '0);
        drive_cycle(0, 1, 1, 1, 36'h8, 0, 1, 1, 1, '0);
        drive_cycle(1, 0, 0, 0, '0, 1, 0, 0, 0, '0);
        // R8: random traffic on both ports
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom();
            pa_ob_ready = r[20]; pa_ib_valid = r[21];
            pb_ob_ready = r[22]; pb_ib_valid = r[23];
            drive_cycle(r[1:0] == 2'b00, r[2], r[3] | r[4], r[5] & r[6], {4'h2, $urandom()},
                        r[9:8] == 2'b00, r[10], r[11] | r[12], r[13] & r[14], {4'h3, $urandom()});
        end
        drive_cycle(1, 0, 0, 0, '0, 1, 0, 0, 0, '0);
        drive_cycle(1, 0, 0, 0, '0, 1, 0, 0, 0, '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule